// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block gathers interrupt requests from a group of peripheral sources and from two sources that cannot be masked: a non-maskable interrupt line (NMI) and an address-break event. Each peripheral has a sticky request flag. The flag is set by a one-cycle event pulse from the peripheral. It stays set until software writes 0 to that bit. Each peripheral also has an enable bit and a one-bit priority level (high or low).

In each evaluation the arbiter picks a single winner. The NMI comes first, then the address break, then any enabled high-level peripheral, then any enabled low-level peripheral. Among peripherals at the same level, the lower source index wins. Peripheral requests are considered only while the CPU's global mask bit is 0.

The winner is committed to the CPU as a request with an identifier and a vector address. The request stays frozen until the CPU accepts it. The CPU accepts by asserting the acknowledge input at an instruction boundary. In the accepting cycle the block signals that the CPU must set its mask bit.

Top module: `prio_intc`

## Requirements
- R1: A pulse on `src_evt[i]` sets `flags[i]` at the next clock edge. When that source is eligible, the request appears on `irq_valid` one edge later, so two edges after the pulse.
- R2: A write with `flag_wr_en` high clears each flag whose `flag_wr_data` bit is 0. It leaves each flag whose data bit is 1 unchanged. If a set event arrives in the same cycle as a clear, the flag ends up set.
- R3: A peripheral whose `src_enable` bit is 0 never wins arbitration, even though its flag still sets. Once the enable bit is raised, the pending flag is presented.
- R4: A high-level peripheral (`src_level_hi` bit 1) wins over any low-level one. The losing request keeps its flag and is presented later, once the winner's flag has been cleared.
- R5: Among peripherals with the same level, the lowest source index wins.
- R6: A rising edge on `nmi_in` is latched and held until the NMI is accepted. A constant high level does not trigger it again. The NMI wins over the address break, and both win over every peripheral, whatever the value of `cpu_mask`.
- R7: A peripheral request is committed only while `cpu_mask` is 0. While `cpu_mask` is 1, the request stays pending with its flag intact.
- R8: Accept happens only in a cycle where `irq_valid`, `irq_ack` and `insn_boundary` are all 1. `mask_set` is 1 in exactly that cycle, and `irq_valid` is 0 after the edge.
- R9: The identifier encoding is 0 for NMI, 1 for address break, and 2+i for peripheral i. `irq_vector` equals `VEC_BASE + 2*irq_id`.
- R10: Once `irq_valid` is 1, it stays 1 with `irq_id` and `irq_vector` unchanged until the accepting edge, even if a higher request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_evt | input | N_SRC | One-cycle request events from peripherals |
| flag_wr_en | input | 1 | Software write strobe for the flag register |
| flag_wr_data | input | N_SRC | Write data; a 0 bit clears that flag |
| flags | output | N_SRC | Current request flags |
| src_enable | input | N_SRC | Per-source enable |
| src_level_hi | input | N_SRC | Per-source priority level, 1 = high |
| nmi_in | input | 1 | Non-maskable interrupt line, edge sensitive |
| abrk_req | input | 1 | Address-break request, level sensitive |
| cpu_mask | input | 1 | CPU global interrupt mask bit |
| insn_boundary | input | 1 | High when the current instruction completes |
| irq_ack | input | 1 | CPU accept handshake |
| irq_valid | output | 1 | A committed request is presented |
| irq_id | output | ID_W | Identifier of the presented source |
| irq_vector | output | ADDR_W | Handler vector address of the presented source |
| mask_set | output | 1 | CPU must set its mask bit (accept cycle) |

## Verification
Several internal faults are visible at the ports:
- A corrupted flag shows on `flags` one edge after the event or write that caused it.
- A wrong arbitration order shows as a wrong identifier and vector at the next accept.
- A lost NMI latch shows as a missing request within two edges of the line's rising edge.
- A presentation register that fails to hold or to release shows as an identifier change while the acknowledge is withheld, or as `irq_valid` still high one edge after an accept.
- A mask gate that leaks shows as a peripheral request appearing while `cpu_mask` is 1, within two edges of its flag.

// File: rtl/intc_pkg.sv
package intc_pkg;

  // Identifier map: fixed slots first, peripherals follow.
  localparam int ID_NMI     = 0;
  localparam int ID_ABRK    = 1;
  localparam int ID_PERIPH0 = 2;

  // Bits needed to number every source including the two fixed slots.
  function automatic int id_bits(int n_src);
    return $clog2(n_src + ID_PERIPH0);
  endfunction

  // Vector slots are two address units apart.
  function automatic logic [31:0] vec_addr(int base, int id);
    return 32'(base) + 32'(2 * id);
  endfunction

endpackage

// File: rtl/intc_flags.sv
module intc_flags #(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] set_evt,
  input  logic             wr_en,
  input  logic [N_SRC-1:0] wr_data,
  output logic [N_SRC-1:0] flag_q
);

  for (genvar g = 0; g < N_SRC; g++) begin : g_bit
    logic clr_b;
    assign clr_b = wr_en & ~wr_data[g];

    // Set has priority over a software clear in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[g] <= 1'b0;
      else        flag_q[g] <= set_evt[g] | (flag_q[g] & ~clr_b);
    end
  end

endmodule

// File: rtl/intc_nmi_edge.sv
module intc_nmi_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_in,
  input  logic take,
  output logic pend
);

  logic line_q;
  logic rise;

  assign rise = nmi_in & ~line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= 1'b0;
      pend   <= 1'b0;
    end else begin
      line_q <= nmi_in;
      pend   <= rise | (pend & ~take);
    end
  end

endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int ID_W  = 4
) (
  input  logic             nmi_pend,
  input  logic             abrk_req,
  input  logic [N_SRC-1:0] flags,
  input  logic [N_SRC-1:0] enable,
  input  logic [N_SRC-1:0] level_hi,
  input  logic             cpu_mask,
  output logic             win_valid,
  output logic [ID_W-1:0]  win_id
);

  logic [N_SRC-1:0] elig;
  logic [N_SRC-1:0] hi_req;
  logic [N_SRC-1:0] lo_req;
  logic             hi_any, lo_any;
  logic [ID_W-1:0]  hi_id, lo_id;

  assign elig   = flags & enable & {N_SRC{~cpu_mask}};
  assign hi_req = elig & level_hi;
  assign lo_req = elig & ~level_hi;

  // Scan from the top index down so the lowest set index is kept last.
  always_comb begin
    hi_any = 1'b0;
    hi_id  = '0;
    lo_any = 1'b0;
    lo_id  = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (hi_req[i]) begin
        hi_any = 1'b1;
        hi_id  = ID_W'(i + ID_PERIPH0);
      end
      if (lo_req[i]) begin
        lo_any = 1'b1;
        lo_id  = ID_W'(i + ID_PERIPH0);
      end
    end
  end

  always_comb begin
    win_valid = 1'b1;
    if (nmi_pend)      win_id = ID_W'(ID_NMI);
    else if (abrk_req) win_id = ID_W'(ID_ABRK);
    else if (hi_any)   win_id = hi_id;
    else if (lo_any)   win_id = lo_id;
    else begin
      win_valid = 1'b0;
      win_id    = '0;
    end
  end

endmodule

// File: rtl/intc_present.sv
module intc_present #(
  parameter int ID_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            win_valid,
  input  logic [ID_W-1:0] win_id,
  input  logic            accept,
  output logic            valid_q,
  output logic [ID_W-1:0] id_q,
  output logic            load
);

  // A new winner is committed only when nothing is being presented.
  assign load = win_valid & ~valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      id_q    <= '0;
    end else if (load) begin
      valid_q <= 1'b1;
      id_q    <= win_id;
    end else if (accept) begin
      valid_q <= 1'b0;
    end
  end

endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter int N_SRC    = 8,
  parameter int ADDR_W   = 16,
  parameter int VEC_BASE = 'h0100,
  localparam int ID_W    = id_bits(N_SRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_evt,
  input  logic              flag_wr_en,
  input  logic [N_SRC-1:0]  flag_wr_data,
  output logic [N_SRC-1:0]  flags,
  input  logic [N_SRC-1:0]  src_enable,
  input  logic [N_SRC-1:0]  src_level_hi,
  input  logic              nmi_in,
  input  logic              abrk_req,
  input  logic              cpu_mask,
  input  logic              insn_boundary,
  input  logic              irq_ack,
  output logic              irq_valid,
  output logic [ID_W-1:0]   irq_id,
  output logic [ADDR_W-1:0] irq_vector,
  output logic              mask_set
);

  logic            nmi_pend_w;
  logic            nmi_take_w;
  logic            win_valid_w;
  logic [ID_W-1:0] win_id_w;
  logic            accept_w;
  logic            load_w;

  intc_flags #(.N_SRC(N_SRC)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (src_evt),
    .wr_en   (flag_wr_en),
    .wr_data (flag_wr_data),
    .flag_q  (flags)
  );

  intc_nmi_edge u_nmi (
    .clk    (clk),
    .rst_n  (rst_n),
    .nmi_in (nmi_in),
    .take   (nmi_take_w),
    .pend   (nmi_pend_w)
  );

  intc_arbiter #(.N_SRC(N_SRC), .ID_W(ID_W)) u_arb (
    .nmi_pend  (nmi_pend_w),
    .abrk_req  (abrk_req),
    .flags     (flags),
    .enable    (src_enable),
    .level_hi  (src_level_hi),
    .cpu_mask  (cpu_mask),
    .win_valid (win_valid_w),
    .win_id    (win_id_w)
  );

  intc_present #(.ID_W(ID_W)) u_pres (
    .clk       (clk),
    .rst_n     (rst_n),
    .win_valid (win_valid_w),
    .win_id    (win_id_w),
    .accept    (accept_w),
    .valid_q   (irq_valid),
    .id_q      (irq_id),
    .load      (load_w)
  );

  assign accept_w   = irq_valid & irq_ack & insn_boundary;
  assign nmi_take_w = accept_w & (irq_id == ID_W'(ID_NMI));
  assign mask_set   = accept_w;
  assign irq_vector = ADDR_W'(vec_addr(VEC_BASE, int'(irq_id)));

endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk #(
  parameter int N_SRC = 8,
  parameter int ID_W  = 4,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_SRC-1:0]  src_evt,
  input logic [N_SRC-1:0]  flags,
  input logic              cpu_mask,
  input logic              irq_valid,
  input logic [ID_W-1:0]   irq_id,
  input logic [ADDR_W-1:0] irq_vector,
  input logic              mask_set,
  input logic              accept_w,
  input logic              nmi_pend_w,
  input logic              load_w
);

  p_flag_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_evt) |=> ((flags & $past(src_evt)) == $past(src_evt)));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !accept_w) |=> (irq_valid && $stable(irq_id) && $stable(irq_vector)));

  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> !irq_valid);

  p_mask_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mask_set |-> irq_valid);

  p_masked_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_valid) && $past(cpu_mask)) |-> (irq_id < ID_W'(2)));

  p_nmi_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_valid) && $past(nmi_pend_w)) |-> (irq_id == '0));

  p_load_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load_w |-> !irq_valid);

  p_id_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (int'(irq_id) <= N_SRC + 1));

endmodule

bind prio_intc prio_intc_chk #(.N_SRC(N_SRC), .ID_W(ID_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .src_evt    (src_evt),
  .flags      (flags),
  .cpu_mask   (cpu_mask),
  .irq_valid  (irq_valid),
  .irq_id     (irq_id),
  .irq_vector (irq_vector),
  .mask_set   (mask_set),
  .accept_w   (accept_w),
  .nmi_pend_w (nmi_pend_w),
  .load_w     (load_w)
);

// File: tb/test_prio_intc.sv
module test_prio_intc;
  localparam int PERIOD   = 10;
  localparam int N        = 8;
  localparam int ADDR_W   = 16;
  localparam int VEC_BASE = 'h0100;
  localparam int ID_W     = $clog2(N + 2);

  logic              clk = 1'b0;
  logic              rst_n;
  logic [N-1:0]      src_evt, flag_wr_data, flags, src_enable, src_level_hi;
  logic              flag_wr_en, nmi_in, abrk_req, cpu_mask, insn_boundary, irq_ack;
  logic              irq_valid, mask_set;
  logic [ID_W-1:0]   irq_id;
  logic [ADDR_W-1:0] irq_vector;

  prio_intc #(.N_SRC(N), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) i_prio_intc (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .flag_wr_en(flag_wr_en),
    .flag_wr_data(flag_wr_data), .flags(flags), .src_enable(src_enable),
    .src_level_hi(src_level_hi), .nmi_in(nmi_in), .abrk_req(abrk_req),
    .cpu_mask(cpu_mask), .insn_boundary(insn_boundary), .irq_ack(irq_ack),
    .irq_valid(irq_valid), .irq_id(irq_id), .irq_vector(irq_vector),
    .mask_set(mask_set)
  );

  always #(PERIOD / 2) clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  typedef struct { int id; string tag; } exp_t;
  exp_t exp_q[$];
  event acc_ev;

  task automatic chk_eq(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_exp(int id, string tag);
    exp_t e;
    e.id = id;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Scoreboard monitor: compares each accept against the oldest expectation.
  always @(acc_ev) begin : mon
    exp_t e;
    if (exp_q.size() == 0) begin
      n_chk++;
      n_err++;
      $display("FAIL R8: unexpected accept actual=%0d expected=none", irq_id);
    end else begin
      e = exp_q.pop_front();
      chk_eq({e.tag, " id"}, 32'(irq_id), 32'(e.id));
      chk_eq({e.tag, " vector R9"}, 32'(irq_vector), 32'(VEC_BASE + (e.id << 1)));
      chk_eq({e.tag, " mask_set R8"}, 32'(mask_set), 32'd1);
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    src_evt = '0; flag_wr_en = 1'b0; flag_wr_data = '0;
    src_enable = '1; src_level_hi = '0;
    nmi_in = 1'b0; abrk_req = 1'b0; cpu_mask = 1'b0;
    insn_boundary = 1'b0; irq_ack = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic pulse_src(logic [N-1:0] m);
    src_evt = m;
    tick();
    src_evt = '0;
  endtask

  task automatic sw_write(logic [N-1:0] d);
    flag_wr_en = 1'b1;
    flag_wr_data = d;
    tick();
    flag_wr_en = 1'b0;
  endtask

  // CPU side: wait for a request, accept it at a boundary, optionally set mask.
  task automatic accept_one(string tag, bit mask_after);
    int k = 0;
    while (!irq_valid && k < 10) begin
      tick();
      k++;
    end
    if (!irq_valid) begin
      n_chk++;
      n_err++;
      $display("FAIL %s: no request presented actual=0 expected=1", tag);
      if (exp_q.size() > 0) exp_q.delete(0);
      return;
    end
    irq_ack = 1'b1;
    insn_boundary = 1'b1;
    #1;
    -> acc_ev;
    tick();
    irq_ack = 1'b0;
    insn_boundary = 1'b0;
    if (mask_after) cpu_mask = 1'b1;
    #1;
    chk_eq({tag, " released R8"}, 32'(irq_valid), 32'd0);
  endtask

  initial begin
    do_reset();
    chk_eq("R1 reset flags", 32'(flags), 32'd0);
    chk_eq("R10 reset valid", 32'(irq_valid), 32'd0);
    chk_eq("R8 reset mask_set", 32'(mask_set), 32'd0);

    // R1 latency and R9 encoding
    pulse_src(8'h08);
    chk_eq("R1 flag set", 32'(flags), 32'h08);
    chk_eq("R1 not yet valid", 32'(irq_valid), 32'd0);
    tick();
    chk_eq("R1 valid after two edges", 32'(irq_valid), 32'd1);
    chk_eq("R9 id of source 3", 32'(irq_id), 32'd5);
    push_exp(5, "R1");
    accept_one("R1", 1);
    sw_write(~8'h08);
    chk_eq("R2 clear by zero", 32'(flags), 32'd0);
    cpu_mask = 1'b0;
    tick(4);
    chk_eq("R2 nothing left", 32'(irq_valid), 32'd0);

    // R2 clear vs set precedence
    cpu_mask = 1'b1;
    pulse_src(8'h14);
    chk_eq("R2 flags set", 32'(flags), 32'h14);
    src_evt = 8'h04;
    sw_write(8'h00);
    src_evt = '0;
    chk_eq("R2 set wins over clear", 32'(flags), 32'h04);
    sw_write(8'hFF);
    chk_eq("R2 one leaves flag", 32'(flags), 32'h04);
    sw_write(~8'h04);
    chk_eq("R2 final clear", 32'(flags), 32'h00);

    // R3 enable gating
    do_reset();
    src_enable = ~8'h10;
    pulse_src(8'h10);
    tick(5);
    chk_eq("R3 disabled no request", 32'(irq_valid), 32'd0);
    chk_eq("R3 flag still set", 32'(flags), 32'h10);
    src_enable = '1;
    push_exp(6, "R3");
    accept_one("R3", 1);

    // R4 level priority and pending kept
    do_reset();
    src_level_hi = 8'h40;
    cpu_mask = 1'b1;
    pulse_src(8'h42);
    cpu_mask = 1'b0;
    push_exp(8, "R4 high");
    accept_one("R4 high", 1);
    sw_write(~8'h40);
    chk_eq("R4 low still pending", 32'(flags), 32'h02);
    cpu_mask = 1'b0;
    push_exp(3, "R4 pending");
    accept_one("R4 pending", 1);

    // R5 default order within a level
    do_reset();
    src_level_hi = 8'h24;
    cpu_mask = 1'b1;
    pulse_src(8'h25);
    cpu_mask = 1'b0;
    push_exp(4, "R5 first high");
    accept_one("R5 first", 1);
    sw_write(~8'h04);
    cpu_mask = 1'b0;
    push_exp(7, "R5 second high");
    accept_one("R5 second", 1);
    sw_write(~8'h20);
    cpu_mask = 1'b0;
    push_exp(2, "R5 low");
    accept_one("R5 low", 1);

    // R7 mask holds peripherals pending
    do_reset();
    cpu_mask = 1'b1;
    pulse_src(8'h80);
    tick(5);
    chk_eq("R7 masked no request", 32'(irq_valid), 32'd0);
    chk_eq("R7 flag kept", 32'(flags), 32'h80);
    cpu_mask = 1'b0;
    push_exp(9, "R7");
    accept_one("R7", 1);

    // R6 NMI and address break bypass the mask
    do_reset();
    cpu_mask = 1'b1;
    src_level_hi = '1;
    pulse_src(8'h01);
    nmi_in = 1'b1;
    tick();
    abrk_req = 1'b1;
    push_exp(0, "R6 nmi");
    accept_one("R6 nmi", 1);
    push_exp(1, "R6 abrk");
    accept_one("R6 abrk", 1);
    abrk_req = 1'b0;
    tick(4);
    chk_eq("R6 held level no retrigger", 32'(irq_valid), 32'd0);
    chk_eq("R6 peripheral still pending", 32'(flags), 32'h01);
    nmi_in = 1'b0;

    // R8 accept needs both ack and boundary
    do_reset();
    pulse_src(8'h02);
    tick();
    irq_ack = 1'b1;
    #1;
    chk_eq("R8 ack alone no mask_set", 32'(mask_set), 32'd0);
    tick();
    chk_eq("R8 ack alone no accept", 32'(irq_valid), 32'd1);
    irq_ack = 1'b0;
    insn_boundary = 1'b1;
    #1;
    chk_eq("R8 boundary alone no mask_set", 32'(mask_set), 32'd0);
    tick();
    chk_eq("R8 boundary alone no accept", 32'(irq_valid), 32'd1);
    insn_boundary = 1'b0;
    push_exp(3, "R8");
    accept_one("R8", 1);

    // R10 presented request frozen against a later NMI
    do_reset();
    pulse_src(8'h01);
    tick();
    nmi_in = 1'b1;
    tick();
    nmi_in = 1'b0;
    tick(3);
    chk_eq("R10 valid held", 32'(irq_valid), 32'd1);
    chk_eq("R10 id held", 32'(irq_id), 32'd2);
    push_exp(2, "R10 held");
    accept_one("R10 held", 1);
    push_exp(0, "R10 nmi after");
    accept_one("R10 nmi after", 1);
    tick(3);
    chk_eq("R10 idle after", 32'(irq_valid), 32'd0);
    chk_eq("R8 scoreboard drained", 32'(exp_q.size()), 32'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog (R1..all): actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule